// File: doc/BRIEF.md
# FIFO Level Interrupt Controller

This block keeps the fill levels of a transmit and a receive byte queue for a serial controller and turns them into interrupt requests. The queue storage is elsewhere. This block sees only push and pop strobes. The bus side pushes transmit bytes and pops receive bytes. The shift engine pops transmit bytes and pushes receive bytes. The shift engine also pulses a transfer-complete strobe when a transfer ends.

Software reaches the block through four word registers, selected by a 2-bit register address:

| Address | Register |
|---|---|
| 0 | Interrupt enable |
| 1 | Interrupt status, write-one-to-clear |
| 2 | Queue control: two trigger levels and two self-clearing flush bits |
| 3 | Queue levels, read-only |

Each of the four interrupt sources has one bit position. That position is the same in the enable register and the status register. The single `irq` output is high whenever an enabled status bit is pending.

The two level sources work as follows:
- **Receive-ready** is pending while the receive count is at or above its trigger.
- **Transmit-request** is pending while the transmit count is at or below its trigger.

Both level sources set again after a clear for as long as their condition holds. The queue depth is a parameter: 128 by default, 64 in the smaller configuration, and at most 255. After reset both triggers equal three quarters of the depth.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Each fill count rises by one on an accepted push and falls by one on an accepted pop. A pop on an empty queue is ignored. A push on a full queue is dropped unless a pop is accepted in the same cycle. Register 3 reads the receive count in bits [7:0] and the transmit count in bits [23:16], with the other bits zero.
- R2: Register 2 reads the receive trigger level in bits [7:0] and the transmit trigger level in bits [23:16]. Bits 15 and 31 always read 0. Both triggers reset to DEPTH/4*3.
- R3: Writing register 2 with bit 15 set empties the receive count, and writing it with bit 31 set empties the transmit count. A write to register 2 updates both trigger fields in every case. A flush leaves the other count unchanged and takes priority over a push to the same queue in that cycle.
- R4: Status bit 0 (receive-ready) sets one cycle after the receive count is greater than or equal to the receive trigger.
- R5: Status bit 4 (transmit-request) sets one cycle after the transmit count is less than or equal to the transmit trigger.
- R6: Status bit 8 (receive-overflow) sets when a receive push meets a full queue with no pop in the same cycle. The count then stays at DEPTH. A push and a pop together on a full queue leave the count at DEPTH and do not raise this bit.
- R7: Status bit 12 (transfer-complete) sets after a pulse on `xfer_done` and stays clear after a clear until the next pulse.
- R8: Writing register 1 clears every status bit written as 1 and leaves bits written as 0 unchanged. Writing all ones clears every pending bit.
- R9: A level bit (bits 0 and 4) reads 0 in the cycle after it is cleared. It sets again on the following cycle if its condition still holds.
- R10: If an event bit (bits 8 and 12) is cleared in the same cycle as its event, the bit stays set.
- R11: Register 0 holds the enables at bit positions 0, 4, 8 and 12, and the other bits read 0. `irq` is high exactly when some status bit and its enable are both 1.
- R12: After reset both counts are 0, the enables and status are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 enable, 1 status, 2 control, 3 levels) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| rx_push | input | 1 | Shift engine stores a received byte |
| rx_pop | input | 1 | Bus side takes a received byte |
| tx_push | input | 1 | Bus side stores a byte to send |
| tx_pop | input | 1 | Shift engine takes a byte to send |
| xfer_done | input | 1 | One-cycle transfer-complete pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bench sweeps every trigger value from 0 to DEPTH against every fill count, so a comparison that is off by one shows up at the exact boundary count. Such a mistake would be a strict compare, or a swapped direction between receive and transmit. Each point first clears the bit and then reads it twice. A design that let set win over clear would never show the cleared cycle. A design that made level bits sticky would fail to set them again.

Pushes on a full queue are checked with and without a pop in the same cycle; a wrong full test would either corrupt the count or raise a spurious overflow. A flush is tested with a push in the same cycle. A clear of the transfer-complete bit is tested with the event in the same cycle. Losing either race would show as a wrong count or a missing bit.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Register word layout: fields shared with the software view.
  localparam int FIELD_W      = 8;
  localparam int LO_LSB       = 0;
  localparam int HI_LSB       = 16;
  localparam int RX_FLUSH_POS = 15;
  localparam int TX_FLUSH_POS = 31;

  // Interrupt sources; bit position in the register word is index * stride.
  localparam int NUM_SRC    = 4;
  localparam int SRC_STRIDE = 4;
  localparam int SRC_RX_RDY = 0;
  localparam int SRC_TX_REQ = 1;
  localparam int SRC_RX_OVF = 2;
  localparam int SRC_DONE   = 3;

  // Sources whose status follows a level condition; the others latch events.
  localparam logic [NUM_SRC-1:0] LEVEL_SRC_MASK = 4'b0011;

  typedef enum logic [1:0] {
    ADDR_IEN = 2'd0,
    ADDR_STS = 2'd1,
    ADDR_CTL = 2'd2,
    ADDR_LVL = 2'd3
  } fir_addr_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  function automatic logic [31:0] spread_src(input src_vec_t v);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < NUM_SRC; i++) w[i*SRC_STRIDE] = v[i];
    return w;
  endfunction

  function automatic src_vec_t gather_src(input logic [31:0] w);
    src_vec_t v;
    for (int i = 0; i < NUM_SRC; i++) v[i] = w[i*SRC_STRIDE];
    return v;
  endfunction

  // Receive side asks for service once it holds enough bytes.
  function automatic logic rx_level_hit(input logic [FIELD_W-1:0] cnt,
                                        input logic [FIELD_W-1:0] trig);
    return cnt >= trig;
  endfunction

  // Transmit side asks for data once it has drained far enough.
  function automatic logic tx_level_hit(input logic [FIELD_W-1:0] cnt,
                                        input logic [FIELD_W-1:0] trig);
    return cnt <= trig;
  endfunction

  function automatic logic [FIELD_W-1:0] default_trig(input int depth);
    return FIELD_W'((depth / 4) * 3);
  endfunction

endpackage

// File: rtl/fir_fill_ctr.sv
module fir_fill_ctr #(
  parameter  int DEPTH = 128,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [CW-1:0] level
);

  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  logic pop_ok;
  logic push_ok;

  // A pop frees a slot in the same cycle, so a full queue still takes a push.
  assign pop_ok  = pop && (level != '0);
  assign push_ok = push && ((level != TOP) || pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (flush) begin
      level <= '0;
    end else if (push_ok && !pop_ok) begin
      level <= level + 1'b1;
    end else if (pop_ok && !push_ok) begin
      level <= level - 1'b1;
    end
  end

endmodule

// File: rtl/fir_irq_status.sv
module fir_irq_status
  import fir_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set,
  input  src_vec_t clr,
  output src_vec_t sts
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_SRC_MASK[i]) begin : g_level
      // Clear wins; a persisting condition sets the bit again next cycle.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sts[i] <= 1'b0;
        else if (clr[i]) sts[i] <= 1'b0;
        else if (set[i]) sts[i] <= 1'b1;
      end
    end else begin : g_event
      // Set wins so a one-cycle event is never lost to a racing clear.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sts[i] <= 1'b0;
        else if (set[i]) sts[i] <= 1'b1;
        else if (clr[i]) sts[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fir_regfile.sv
module fir_regfile
  import fir_pkg::*;
#(
  parameter logic [FIELD_W-1:0] TRIG_RST = 8'd96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [1:0]         addr,
  input  logic [31:0]        wdata,
  input  src_vec_t           sts,
  input  logic [FIELD_W-1:0] rx_level8,
  input  logic [FIELD_W-1:0] tx_level8,
  output logic [31:0]        rdata,
  output src_vec_t           ien,
  output logic [FIELD_W-1:0] rx_trig,
  output logic [FIELD_W-1:0] tx_trig,
  output logic               rx_flush,
  output logic               tx_flush,
  output src_vec_t           sts_clr
);

  fir_addr_e sel;
  logic      hit_ien;
  logic      hit_sts;
  logic      hit_ctl;
  logic      unused_wbits;

  assign sel     = fir_addr_e'(addr);
  assign hit_ien = wr && (sel == ADDR_IEN);
  assign hit_sts = wr && (sel == ADDR_STS);
  assign hit_ctl = wr && (sel == ADDR_CTL);

  assign sts_clr  = hit_sts ? gather_src(wdata) : '0;
  assign rx_flush = hit_ctl && wdata[RX_FLUSH_POS];
  assign tx_flush = hit_ctl && wdata[TX_FLUSH_POS];

  assign unused_wbits = ^{wdata[30:24], wdata[14:13], wdata[11:9]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= '0;
      rx_trig <= TRIG_RST;
      tx_trig <= TRIG_RST;
    end else begin
      if (hit_ien) ien <= gather_src(wdata);
      if (hit_ctl) begin
        rx_trig <= wdata[LO_LSB +: FIELD_W];
        tx_trig <= wdata[HI_LSB +: FIELD_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      ADDR_IEN: rdata = spread_src(ien);
      ADDR_STS: rdata = spread_src(sts);
      ADDR_CTL: begin
        rdata[LO_LSB +: FIELD_W] = rx_trig;
        rdata[HI_LSB +: FIELD_W] = tx_trig;
      end
      ADDR_LVL: begin
        rdata[LO_LSB +: FIELD_W] = rx_level8;
        rdata[HI_LSB +: FIELD_W] = tx_level8;
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fir_pkg::*;
#(
  parameter int DEPTH = 128  // 1 .. 255, so a count fits its 8-bit field
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_push,
  input  logic        rx_pop,
  input  logic        tx_push,
  input  logic        tx_pop,
  input  logic        xfer_done,
  output logic        irq
);

  localparam int            CW       = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [CW-1:0]      rx_level;
  logic [CW-1:0]      tx_level;
  logic [FIELD_W-1:0] rx_level8;
  logic [FIELD_W-1:0] tx_level8;
  logic [FIELD_W-1:0] rx_trig;
  logic [FIELD_W-1:0] tx_trig;
  logic               rx_flush;
  logic               tx_flush;

  // Named internal events, observed by the bound checker.
  logic     rx_full;
  logic     rx_ovf_evt;
  logic     rx_rdy_hit;
  logic     tx_req_hit;
  src_vec_t sts_set;
  src_vec_t sts_clr;
  src_vec_t sts;
  src_vec_t ien;

  fir_fill_ctr #(.DEPTH(DEPTH)) u_rx_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .pop   (rx_pop),
    .flush (rx_flush),
    .level (rx_level)
  );

  fir_fill_ctr #(.DEPTH(DEPTH)) u_tx_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .pop   (tx_pop),
    .flush (tx_flush),
    .level (tx_level)
  );

  assign rx_level8  = FIELD_W'(rx_level);
  assign tx_level8  = FIELD_W'(tx_level);
  assign rx_full    = (rx_level == FULL_LVL);
  assign rx_ovf_evt = rx_push && rx_full && !rx_pop;
  assign rx_rdy_hit = rx_level_hit(rx_level8, rx_trig);
  assign tx_req_hit = tx_level_hit(tx_level8, tx_trig);

  always_comb begin
    sts_set             = '0;
    sts_set[SRC_RX_RDY] = rx_rdy_hit;
    sts_set[SRC_TX_REQ] = tx_req_hit;
    sts_set[SRC_RX_OVF] = rx_ovf_evt;
    sts_set[SRC_DONE]   = xfer_done;
  end

  fir_irq_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sts_set),
    .clr   (sts_clr),
    .sts   (sts)
  );

  fir_regfile #(.TRIG_RST(default_trig(DEPTH))) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .sts       (sts),
    .rx_level8 (rx_level8),
    .tx_level8 (tx_level8),
    .rdata     (reg_rdata),
    .ien       (ien),
    .rx_trig   (rx_trig),
    .tx_trig   (tx_trig),
    .rx_flush  (rx_flush),
    .tx_flush  (tx_flush),
    .sts_clr   (sts_clr)
  );

  assign irq = |(sts & ien);

endmodule

// File: rtl/fir_chk.sv
module fir_chk #(
  parameter  int DEPTH = 128,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          xfer_done,
  input logic          irq,
  input logic          rx_flush,
  input logic          tx_flush,
  input logic [3:0]    sts_clr,
  input logic [3:0]    sts,
  input logic [3:0]    ien,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] tx_level,
  input logic [7:0]    rx_trig,
  input logic [7:0]    tx_trig
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  // R1
  rx_level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= FULL_LVL);

  // R1
  tx_level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= FULL_LVL);

  // R3
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_level == '0));

  // R3
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_level == '0));

  // R6
  rx_ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_level == FULL_LVL) |=> sts[2]);

  // R6
  rx_ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && !rx_flush && rx_level == FULL_LVL) |=> (rx_level == FULL_LVL));

  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> sts[3]);

  // R9
  rx_rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(rx_level) >= int'(rx_trig)) && !sts_clr[0]) |=> sts[0]);

  // R5
  tx_req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(tx_level) <= int'(tx_trig)) && !sts_clr[1]) |=> sts[1]);

  // R9
  level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr[0] |=> !sts[0]);

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'b0000) |-> !irq);

endmodule

bind fifo_irq_ctrl fir_chk #(.DEPTH(DEPTH)) u_fir_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_push   (rx_push),
  .rx_pop    (rx_pop),
  .xfer_done (xfer_done),
  .irq       (irq),
  .rx_flush  (rx_flush),
  .tx_flush  (tx_flush),
  .sts_clr   (sts_clr),
  .sts       (sts),
  .ien       (ien),
  .rx_level  (rx_level),
  .tx_level  (tx_level),
  .rx_trig   (rx_trig),
  .tx_trig   (tx_trig)
);

// File: tb/sim_fifo_irq_ctrl.sv
module sim_fifo_irq_ctrl;

  localparam int DEPTH = 16;
  localparam int TRIG0 = (DEPTH / 4) * 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_push = 1'b0;
  logic        rx_pop = 1'b0;
  logic        tx_push = 1'b0;
  logic        tx_pop = 1'b0;
  logic        xfer_done = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2ns clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .tx_push   (tx_push),
    .tx_pop    (tx_pop),
    .xfer_done (xfer_done),
    .irq       (irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #100ps;
    d = reg_rdata;
  endtask

  task automatic strobe(input logic rpu, input logic rpo, input logic tpu,
                        input logic tpo, input logic dn);
    @(negedge clk);
    rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo; xfer_done = dn;
    @(negedge clk);
    rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; xfer_done = 1'b0;
  endtask

  function automatic logic [31:0] ctl_word(input bit rxf, input bit txf,
                                           input int rxt, input int txt);
    return {txf, 7'd0, 8'(txt), rxf, 7'd0, 8'(rxt)};
  endfunction

  function automatic logic [31:0] lvl_word(input int rxc, input int txc);
    return {8'd0, 8'(txc), 8'd0, 8'(rxc)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;

    // R12 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd3, d); check("R12", "levels after reset", d, 32'h0);
    rd(2'd0, d); check("R12", "enables after reset", d, 32'h0);
    rd(2'd1, d); check("R12", "status after reset", d, 32'h0);
    check("R12", "irq after reset", 32'(irq), 32'h0);
    rd(2'd2, d); check("R2", "trigger reset value", d, ctl_word(0, 0, TRIG0, TRIG0));
    @(negedge clk);
    rd(2'd1, d); check("R5", "tx request with empty queue", d, 32'h10);

    // R4 R9 R11 receive-ready sweep over every trigger and count
    reg_write(2'd0, 32'h1);
    for (int t = 0; t <= DEPTH; t++) begin
      reg_write(2'd2, ctl_word(1, 1, t, TRIG0));
      for (int c = 0; c <= DEPTH; c++) begin
        reg_write(2'd1, 32'h1);
        rd(2'd1, d); check("R9", "rx ready after clear", 32'(d[0]), 32'h0);
        @(negedge clk);
        rd(2'd1, d); check("R4", "rx ready level", 32'(d[0]), 32'(c >= t));
        check("R11", "irq follows rx ready", 32'(irq), 32'(c >= t));
        rd(2'd3, d); check("R1", "rx count", d, lvl_word(c, 0));
        if (c < DEPTH) strobe(1, 0, 0, 0, 0);
      end
    end

    // R5 transmit-request sweep
    reg_write(2'd0, 32'h10);
    for (int t = 0; t <= DEPTH; t++) begin
      reg_write(2'd2, ctl_word(1, 1, TRIG0, t));
      for (int c = 0; c <= DEPTH; c++) begin
        reg_write(2'd1, 32'h10);
        rd(2'd1, d); check("R9", "tx request after clear", 32'(d[4]), 32'h0);
        @(negedge clk);
        rd(2'd1, d); check("R5", "tx request level", 32'(d[4]), 32'(c <= t));
        check("R11", "irq follows tx request", 32'(irq), 32'(c <= t));
        rd(2'd3, d); check("R1", "tx count", d, lvl_word(0, c));
        if (c < DEPTH) strobe(0, 0, 1, 0, 0);
      end
    end

    // R1 push on full transmit queue dropped, pops drain, pop on empty ignored
    strobe(0, 0, 1, 0, 0);
    rd(2'd3, d); check("R1", "tx push when full dropped", d, lvl_word(0, DEPTH));
    for (int k = 0; k < DEPTH + 2; k++) strobe(0, 0, 0, 1, 0);
    rd(2'd3, d); check("R1", "tx drained, extra pops ignored", d, lvl_word(0, 0));

    // R6 receive overflow
    reg_write(2'd0, 32'h0);
    reg_write(2'd2, ctl_word(1, 1, TRIG0, TRIG0));
    for (int k = 0; k < DEPTH; k++) strobe(1, 0, 0, 0, 0);
    reg_write(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R6", "overflow clear before test", 32'(d[8]), 32'h0);
    strobe(1, 0, 0, 0, 0);
    rd(2'd3, d); check("R6", "overflow byte dropped", d, lvl_word(DEPTH, 0));
    rd(2'd1, d); check("R6", "overflow flagged", 32'(d[8]), 32'h1);
    reg_write(2'd1, 32'h100);
    strobe(1, 1, 0, 0, 0);
    rd(2'd3, d); check("R6", "push with pop at full", d, lvl_word(DEPTH, 0));
    rd(2'd1, d); check("R6", "no overflow with pop", 32'(d[8]), 32'h0);
    strobe(0, 1, 0, 0, 0);
    strobe(1, 0, 0, 0, 0);
    rd(2'd3, d); check("R1", "refill to full", d, lvl_word(DEPTH, 0));
    rd(2'd1, d); check("R6", "no overflow on last slot", 32'(d[8]), 32'h0);

    // R3 flush
    for (int k = 0; k < 5; k++) strobe(0, 0, 1, 0, 0);
    reg_write(2'd2, ctl_word(1, 0, 7, 9));
    rd(2'd3, d); check("R3", "rx flush keeps tx", d, lvl_word(0, 5));
    rd(2'd2, d); check("R2", "flush bits read 0", d, ctl_word(0, 0, 7, 9));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = ctl_word(0, 1, 7, 9); tx_push = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; tx_push = 1'b0;
    rd(2'd3, d); check("R3", "tx flush beats push", d, lvl_word(0, 0));

    // R7 R10 transfer complete
    reg_write(2'd2, ctl_word(0, 0, 255, 0));
    strobe(0, 0, 1, 0, 0);
    reg_write(2'd1, 32'hFFFF_FFFF);
    strobe(0, 0, 0, 0, 1);
    rd(2'd1, d); check("R7", "done flagged", 32'(d[12]), 32'h1);
    reg_write(2'd1, 32'h1000);
    rd(2'd1, d); check("R7", "done cleared", 32'(d[12]), 32'h0);
    @(negedge clk);
    rd(2'd1, d); check("R7", "done stays clear", 32'(d[12]), 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1000; xfer_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; xfer_done = 1'b0;
    rd(2'd1, d); check("R10", "event beats clear", 32'(d[12]), 32'h1);

    // R8 R11 write-one-to-clear and masking
    for (int k = 0; k < DEPTH + 1; k++) strobe(1, 0, 0, 0, 0);
    reg_write(2'd1, 32'h11);
    rd(2'd1, d); check("R8", "pending events", d, 32'h1100);
    reg_write(2'd1, 32'h0);
    rd(2'd1, d); check("R8", "zero write keeps bits", d, 32'h1100);
    check("R11", "irq masked", 32'(irq), 32'h0);
    reg_write(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R11", "enable readback", d, 32'h1111);
    check("R11", "irq enabled", 32'(irq), 32'h1);
    reg_write(2'd0, 32'h11);
    check("R11", "irq with unrelated enables", 32'(irq), 32'h0);
    reg_write(2'd1, 32'h100);
    rd(2'd1, d); check("R8", "single bit cleared", d, 32'h1000);
    reg_write(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R8", "all ones clears", d, 32'h0);
    @(negedge clk);
    rd(2'd1, d); check("R8", "stays clear", d, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule